// File: doc/BRIEF.md
# UART Host Register Front End

This block is the host-facing register file of a 16550-style serial port sitting on a 32-bit bus. The host issues single-cycle read or write strobes with a byte address; registers sit on a 4-byte stride, so the two low address bits play no part in decoding. A bank-select bit (bit 7 of the line-control register) steers the two lowest word offsets between the data and interrupt-enable registers and the two bytes of the baud divisor. Where one offset holds both a read-only and a write-only register, a read reaches one and a write reaches the other.

Received characters reach the host either from a single holding register (FIFO disabled) or from the head of an external receive FIFO (FIFO enabled). The block owns the data-ready flag in both modes. It narrows characters to the configured length, pulses a pop to the FIFO, and presents a load strobe with the byte to the transmitter. Shifting, baud generation, FIFO storage and the infrared encoder live elsewhere and attach through plain strobe and status ports.

Top module: `uart_host_regs`

## Requirements
- R1: After reset every configuration output (line control, interrupt enable, modem control, divisor, infrared select, FIFO mode) is 0, rxReady is 0, and busRData is 0.
- R2: Word offset 0 (byte address 0x00): with the bank bit (lineCtl bit 7) at 0, a write pulses txLoad in the same cycle with txData = busWData[7:0], and a read returns the receive byte. With the bank bit at 1, reads and writes reach the divisor low byte (divisorOut[7:0]) and txLoad stays 0.
- R3: Word offset 1 (0x04) is the interrupt-enable register (ierOut) with the bank bit at 0 and the divisor high byte (divisorOut[15:8]) with it at 1.
- R4: Word offset 2 (0x08) reads iirIn whatever the bank bit. A write there pulses fcrWrite with fcrData = busWData[7:0] in the same cycle, sets fifoMode from busWData[0] from the next cycle, and empties the holding register and data-ready flag.
- R5: Offsets 0x0C, 0x10, 0x14, 0x18, 0x1C and 0x20 are line control, modem control, line status, modem status, scratch and infrared select, whatever the bank bit. Line status reads {lsrIn[7:1], rxReady}. Writes to line status and modem status change nothing.
- R6: With fifoMode 0, rxPush loads rxData into the holding register and sets rxReady from the next cycle. A host read of offset 0 (bank bit 0) clears the holding register to 0 and rxReady to 0 from the next cycle. A push in the same cycle as that read wins.
- R7: The receive byte is right-justified to the length in lineCtl[1:0] (00 = 5, 01 = 6, 10 = 7, 11 = 8 bits), with the unused high bits read as 0.
- R8: With fifoMode 1, a read of offset 0 (bank bit 0) returns fifoHeadData, narrowed as in R7. It pulses fifoPop in the same cycle only when fifoEmpty is 0. rxReady equals !fifoEmpty, and rxPush is ignored.
- R9: busRData[31:8] always reads 0. Reads of offsets above 0x20 return 0, and writes to them change nothing. Address bits [1:0] have no effect on decoding.
- R10: busRData is valid in the cycle the read strobe is high and is 0 in every cycle without a read strobe. Write effects appear from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Single-cycle access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, combinational |
| rxPush | input | 1 | Character received (FIFO disabled) |
| rxData | input | 8 | Received character, LSB-first assembled |
| fifoHeadData | input | 8 | Byte at the head of the receive FIFO |
| fifoEmpty | input | 1 | Receive FIFO empty |
| fifoPop | output | 1 | Pop the receive FIFO head |
| iirIn | input | 8 | Interrupt identification value |
| lsrIn | input | 8 | Line status bits 7:1 (bit 0 unused) |
| msrIn | input | 8 | Modem status value |
| txLoad | output | 1 | Load transmit holding byte |
| txData | output | 8 | Transmit byte |
| fcrWrite | output | 1 | FIFO control written |
| fcrData | output | 8 | FIFO control value |
| fifoMode | output | 1 | FIFO mode enabled |
| lcrOut | output | 8 | Line control register |
| ierOut | output | 8 | Interrupt enable register |
| mcrOut | output | 8 | Modem control register |
| divisorOut | output | 16 | Baud divisor |
| irSelOut | output | 8 | Infrared select register |
| rxReady | output | 1 | Data-ready flag |

## Verification
Read data, txLoad, fcrWrite and fifoPop are due in the same cycle as the strobe. The bench samples them 2 ns after driving inputs and before the next rising edge. Register contents, fifoMode and rxReady change at the rising edge that ends the strobe, so the bench compares them at the following falling edge against a behavioural model that it updates at that same edge. The modelled FIFO is a queue; the bench updates its head and empty status just after each edge, so a pop is visible one cycle later.

// File: rtl/uart_host_regs_pkg.sv
package uart_host_regs_pkg;
  localparam int BYTE_W = 8;

  // word offsets (byte address >> 2)
  localparam int OFF_RXTX   = 0;
  localparam int OFF_INTEN  = 1;
  localparam int OFF_INTID  = 2;
  localparam int OFF_LINE   = 3;
  localparam int OFF_MODEM  = 4;
  localparam int OFF_LSTAT  = 5;
  localparam int OFF_MSTAT  = 6;
  localparam int OFF_SCR    = 7;
  localparam int OFF_IRSEL  = 8;

  localparam int BANK_BIT   = 7;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RXBUF, SEL_DIVLO, SEL_INTEN, SEL_DIVHI, SEL_INTID,
    SEL_LINECTL, SEL_MODEMCTL, SEL_LINESTAT, SEL_MODEMSTAT, SEL_SCRATCH, SEL_IRSEL
  } regSelT;

  typedef struct packed {
    logic   wrTx;
    logic   wrDivLo;
    logic   wrDivHi;
    logic   wrIntEn;
    logic   wrFifoCtl;
    logic   wrLineCtl;
    logic   wrModemCtl;
    logic   wrScratch;
    logic   wrIrSel;
    logic   rdRxBuf;
    logic   popFifo;
    regSelT rdSel;
  } regStrobeT;
endpackage

// File: rtl/uart_host_regs_ctrl.sv
module uart_host_regs_ctrl
  import uart_host_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              bankSel,
  input  logic              fifoMode,
  input  logic              fifoEmpty,
  output regStrobeT         strobe
);
  localparam int OFF_W = ADDR_W - 2;

  logic [OFF_W-1:0] wordOff;
  logic rdEn, wrEn;

  assign wordOff = busAddr[ADDR_W-1:2];
  assign rdEn    = busSel & ~busWrite;
  assign wrEn    = busSel & busWrite;

  always_comb begin
    strobe       = '0;
    strobe.rdSel = SEL_NONE;
    if (rdEn) begin
      case (wordOff)
        OFF_W'(OFF_RXTX): begin
          if (bankSel) strobe.rdSel = SEL_DIVLO;
          else begin
            strobe.rdSel   = SEL_RXBUF;
            strobe.rdRxBuf = 1'b1;
            strobe.popFifo = fifoMode & ~fifoEmpty;
          end
        end
        OFF_W'(OFF_INTEN): strobe.rdSel = bankSel ? SEL_DIVHI : SEL_INTEN;
        OFF_W'(OFF_INTID): strobe.rdSel = SEL_INTID;
        OFF_W'(OFF_LINE):  strobe.rdSel = SEL_LINECTL;
        OFF_W'(OFF_MODEM): strobe.rdSel = SEL_MODEMCTL;
        OFF_W'(OFF_LSTAT): strobe.rdSel = SEL_LINESTAT;
        OFF_W'(OFF_MSTAT): strobe.rdSel = SEL_MODEMSTAT;
        OFF_W'(OFF_SCR):   strobe.rdSel = SEL_SCRATCH;
        OFF_W'(OFF_IRSEL): strobe.rdSel = SEL_IRSEL;
        default:           strobe.rdSel = SEL_NONE;
      endcase
    end
    if (wrEn) begin
      case (wordOff)
        OFF_W'(OFF_RXTX): begin
          if (bankSel) strobe.wrDivLo = 1'b1;
          else         strobe.wrTx    = 1'b1;
        end
        OFF_W'(OFF_INTEN): begin
          if (bankSel) strobe.wrDivHi = 1'b1;
          else         strobe.wrIntEn = 1'b1;
        end
        OFF_W'(OFF_INTID): strobe.wrFifoCtl  = 1'b1;
        OFF_W'(OFF_LINE):  strobe.wrLineCtl  = 1'b1;
        OFF_W'(OFF_MODEM): strobe.wrModemCtl = 1'b1;
        OFF_W'(OFF_SCR):   strobe.wrScratch  = 1'b1;
        OFF_W'(OFF_IRSEL): strobe.wrIrSel    = 1'b1;
        default: ;  // status offsets and unmapped space: no effect
      endcase
    end
  end
endmodule

// File: rtl/uart_host_regs_datapath.sv
module uart_host_regs_datapath
  import uart_host_regs_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobeT         strobe,
  input  logic [BUS_W-1:0]  busWData,
  output logic [BUS_W-1:0]  busRData,
  input  logic              rxPush,
  input  logic [BYTE_W-1:0] rxData,
  input  logic [BYTE_W-1:0] fifoHeadData,
  input  logic              fifoEmpty,
  input  logic [BYTE_W-1:0] iirIn,
  input  logic [BYTE_W-1:0] lsrIn,
  input  logic [BYTE_W-1:0] msrIn,
  output logic [BYTE_W-1:0] txData,
  output logic [BYTE_W-1:0] fcrData,
  output logic              fifoMode,
  output logic [BYTE_W-1:0] lcrOut,
  output logic [BYTE_W-1:0] ierOut,
  output logic [BYTE_W-1:0] mcrOut,
  output logic [2*BYTE_W-1:0] divisorOut,
  output logic [BYTE_W-1:0] irSelOut,
  output logic              rxReady
);
  logic [BYTE_W-1:0] wrByte;
  logic [BYTE_W-1:0] divLo, divHi, scratch, holdReg;
  logic              holdValid;
  logic [BYTE_W-1:0] charMask;
  logic [BYTE_W-1:0] rxByte;
  logic [BYTE_W-1:0] rdByte;

  assign wrByte = busWData[BYTE_W-1:0];

  // configuration registers, one per write strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lcrOut   <= '0;
      ierOut   <= '0;
      mcrOut   <= '0;
      divLo    <= '0;
      divHi    <= '0;
      scratch  <= '0;
      irSelOut <= '0;
      fifoMode <= 1'b0;
    end else begin
      if (strobe.wrLineCtl)  lcrOut   <= wrByte;
      if (strobe.wrIntEn)    ierOut   <= wrByte;
      if (strobe.wrModemCtl) mcrOut   <= wrByte;
      if (strobe.wrDivLo)    divLo    <= wrByte;
      if (strobe.wrDivHi)    divHi    <= wrByte;
      if (strobe.wrScratch)  scratch  <= wrByte;
      if (strobe.wrIrSel)    irSelOut <= wrByte;
      if (strobe.wrFifoCtl)  fifoMode <= wrByte[0];
    end
  end

  // single-character holding register for non-FIFO operation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg   <= '0;
      holdValid <= 1'b0;
    end else if (strobe.wrFifoCtl) begin
      holdReg   <= '0;
      holdValid <= 1'b0;
    end else if (!fifoMode && rxPush) begin
      holdReg   <= rxData;
      holdValid <= 1'b1;
    end else if (!fifoMode && strobe.rdRxBuf) begin
      holdReg   <= '0;
      holdValid <= 1'b0;
    end
  end

  assign divisorOut = {divHi, divLo};
  assign txData     = wrByte;
  assign fcrData    = wrByte;
  assign rxReady    = fifoMode ? ~fifoEmpty : holdValid;

  // word length code 0..3 keeps 5..8 low bits
  assign charMask = {BYTE_W{1'b1}} >> (2'd3 - lcrOut[1:0]);
  assign rxByte   = (fifoMode ? fifoHeadData : holdReg) & charMask;

  always_comb begin
    unique case (strobe.rdSel)
      SEL_RXBUF:     rdByte = rxByte;
      SEL_DIVLO:     rdByte = divLo;
      SEL_INTEN:     rdByte = ierOut;
      SEL_DIVHI:     rdByte = divHi;
      SEL_INTID:     rdByte = iirIn;
      SEL_LINECTL:   rdByte = lcrOut;
      SEL_MODEMCTL:  rdByte = mcrOut;
      SEL_LINESTAT:  rdByte = {lsrIn[BYTE_W-1:1], rxReady};
      SEL_MODEMSTAT: rdByte = msrIn;
      SEL_SCRATCH:   rdByte = scratch;
      SEL_IRSEL:     rdByte = irSelOut;
      default:       rdByte = '0;
    endcase
  end

  assign busRData = BUS_W'(rdByte);
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWData,
  output logic [BUS_W-1:0]  busRData,
  input  logic              rxPush,
  input  logic [7:0]        rxData,
  input  logic [7:0]        fifoHeadData,
  input  logic              fifoEmpty,
  output logic              fifoPop,
  input  logic [7:0]        iirIn,
  input  logic [7:0]        lsrIn,
  input  logic [7:0]        msrIn,
  output logic              txLoad,
  output logic [7:0]        txData,
  output logic              fcrWrite,
  output logic [7:0]        fcrData,
  output logic              fifoMode,
  output logic [7:0]        lcrOut,
  output logic [7:0]        ierOut,
  output logic [7:0]        mcrOut,
  output logic [15:0]       divisorOut,
  output logic [7:0]        irSelOut,
  output logic              rxReady
);
  regStrobeT strobe;

  uart_host_regs_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .bankSel   (lcrOut[BANK_BIT]),
    .fifoMode  (fifoMode),
    .fifoEmpty (fifoEmpty),
    .strobe    (strobe)
  );

  uart_host_regs_datapath #(.BUS_W(BUS_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .busWData     (busWData),
    .busRData     (busRData),
    .rxPush       (rxPush),
    .rxData       (rxData),
    .fifoHeadData (fifoHeadData),
    .fifoEmpty    (fifoEmpty),
    .iirIn        (iirIn),
    .lsrIn        (lsrIn),
    .msrIn        (msrIn),
    .txData       (txData),
    .fcrData      (fcrData),
    .fifoMode     (fifoMode),
    .lcrOut       (lcrOut),
    .ierOut       (ierOut),
    .mcrOut       (mcrOut),
    .divisorOut   (divisorOut),
    .irSelOut     (irSelOut),
    .rxReady      (rxReady)
  );

  assign txLoad   = strobe.wrTx;
  assign fcrWrite = strobe.wrFifoCtl;
  assign fifoPop  = strobe.popFifo;
endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BUS_W-1:0]  busRData,
  input logic              rxPush,
  input logic              fifoEmpty,
  input logic              fifoPop,
  input logic              txLoad,
  input logic              fifoMode,
  input logic [7:0]        lcrOut,
  input logic              rxReady
);
  logic [ADDR_W-3:0] wOff;
  logic rxBufRead, fcrWr;
  assign wOff      = busAddr[ADDR_W-1:2];
  assign rxBufRead = busSel && !busWrite && wOff == '0 && !lcrOut[7];
  assign fcrWr     = busSel && busWrite && wOff == (ADDR_W-2)'(2);

  a_r2_tx_load_decode: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |-> (busSel && busWrite && wOff == '0 && !lcrOut[7]));

  a_r6_ready_on_push: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && rxPush && !fcrWr) |=> rxReady);

  a_r6_ready_clears_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && rxBufRead && !rxPush) |=> !rxReady);

  a_r8_pop_gated: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (fifoMode && !fifoEmpty && rxBufRead));

  a_r8_ready_tracks_fifo: assert property (@(posedge clk) disable iff (!rstN)
    fifoMode |-> (rxReady == !fifoEmpty));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRData[BUS_W-1:8] == '0);

  a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWrite) |-> busRData == '0);
endmodule

bind uart_host_regs uart_host_regs_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busRData  (busRData),
  .rxPush    (rxPush),
  .fifoEmpty (fifoEmpty),
  .fifoPop   (fifoPop),
  .txLoad    (txLoad),
  .fifoMode  (fifoMode),
  .lcrOut    (lcrOut),
  .rxReady   (rxReady)
);

// File: tb/tb_uart_host_regs.sv
`timescale 1ns/1ps
module tb_uart_host_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 0, busWrite = 0;
  logic [7:0]  busAddr = 0;
  logic [31:0] busWData = 0;
  logic [31:0] busRData;
  logic        rxPush = 0;
  logic [7:0]  rxData = 0, fifoHeadData = 0;
  logic        fifoEmpty = 1;
  logic        fifoPop;
  logic [7:0]  iirIn = 8'hC1, lsrIn = 8'h61, msrIn = 8'hB0;
  logic        txLoad, fcrWrite, fifoMode, rxReady;
  logic [7:0]  txData, fcrData, lcrOut, ierOut, mcrOut, irSelOut;
  logic [15:0] divisorOut;

  int checks = 0, failures = 0;
  bit finished = 0;

  // behavioural model
  byte unsigned q[$];
  byte unsigned mLcr, mIer, mMcr, mDll, mDlm, mScr, mIrs, mHold;
  bit mFifo, mDr;

  always #10 clk = ~clk;

  uart_host_regs dut (.*);

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit mReady();
    return mFifo ? (q.size() != 0) : mDr;
  endfunction

  function automatic logic [7:0] mMask();
    case (mLcr[1:0])
      2'd0: return 8'h1F;
      2'd1: return 8'h3F;
      2'd2: return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [31:0] mRead(logic [7:0] a);
    bit bank = mLcr[7];
    byte unsigned head = (q.size() != 0) ? q[0] : 8'h00;
    case (a[7:2])
      6'd0: return bank ? 32'(mDll) : 32'((mFifo ? head : mHold) & mMask());
      6'd1: return bank ? 32'(mDlm) : 32'(mIer);
      6'd2: return 32'(iirIn);
      6'd3: return 32'(mLcr);
      6'd4: return 32'(mMcr);
      6'd5: return 32'({lsrIn[7:1], mReady()});
      6'd6: return 32'(msrIn);
      6'd7: return 32'(mScr);
      6'd8: return 32'(mIrs);
      default: return 32'h0;
    endcase
  endfunction

  task automatic setFifoPins();
    fifoEmpty    = (q.size() == 0);
    fifoHeadData = (q.size() != 0) ? q[0] : 8'h00;
  endtask

  // one bus cycle; inputs driven after a falling edge
  task automatic step(bit sel, bit wr, logic [7:0] a, logic [31:0] wd, bit push,
                      logic [7:0] pd, string req);
    bit rd, bank, expTx, expPop, expFcr;
    busSel = sel; busWrite = wr; busAddr = a; busWData = wd;
    rxPush = push; rxData = pd;
    #2;
    rd     = sel && !wr;
    bank   = mLcr[7];
    expTx  = sel && wr && a[7:2] == 0 && !bank;
    expFcr = sel && wr && a[7:2] == 2;
    expPop = rd && a[7:2] == 0 && !bank && mFifo && q.size() != 0;
    check(busRData == (rd ? mRead(a) : 32'h0), {req, " R10 read data"}, busRData,
          rd ? mRead(a) : 32'h0);
    check(txLoad == expTx, "R2 txLoad", 32'(txLoad), 32'(expTx));
    if (expTx) check(txData == wd[7:0], "R2 txData", 32'(txData), 32'(wd[7:0]));
    check(fcrWrite == expFcr, "R4 fcrWrite", 32'(fcrWrite), 32'(expFcr));
    if (expFcr) check(fcrData == wd[7:0], "R4 fcrData", 32'(fcrData), 32'(wd[7:0]));
    check(fifoPop == expPop, "R8 fifoPop", 32'(fifoPop), 32'(expPop));
    @(posedge clk);
    if (sel && wr) begin
      case (a[7:2])
        6'd0: if (bank) mDll = wd[7:0];
        6'd1: if (bank) mDlm = wd[7:0]; else mIer = wd[7:0];
        6'd3: mLcr = wd[7:0];
        6'd4: mMcr = wd[7:0];
        6'd7: mScr = wd[7:0];
        6'd8: mIrs = wd[7:0];
        default: ;
      endcase
    end
    if (rd && a[7:2] == 0 && !bank) begin
      if (mFifo) begin
        if (q.size() != 0) void'(q.pop_front());
      end else begin
        mHold = 0; mDr = 0;
      end
    end
    if (push && !mFifo) begin mHold = pd; mDr = 1; end
    if (expFcr) begin mFifo = wd[0]; mHold = 0; mDr = 0; end
    #1 setFifoPins();
    busSel = 0; rxPush = 0;
    @(negedge clk);
    check(lcrOut == mLcr, "R5 lcrOut", 32'(lcrOut), 32'(mLcr));
    check(mcrOut == mMcr, "R5 mcrOut", 32'(mcrOut), 32'(mMcr));
    check(irSelOut == mIrs, "R5 irSelOut", 32'(irSelOut), 32'(mIrs));
    check(ierOut == mIer, "R3 ierOut", 32'(ierOut), 32'(mIer));
    check(divisorOut == {mDlm, mDll}, "R3 divisorOut", 32'(divisorOut), 32'({mDlm, mDll}));
    check(fifoMode == mFifo, "R4 fifoMode", 32'(fifoMode), 32'(mFifo));
    check(rxReady == mReady(), "R6 rxReady", 32'(rxReady), 32'(mReady()));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string req);
    step(1, 1, a, d, 0, 0, req);
  endtask
  task automatic rd(logic [7:0] a, string req);
    step(1, 0, a, 0, 0, 0, req);
  endtask
  task automatic push(logic [7:0] d, string req);
    step(0, 0, 0, 0, 1, d, req);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(lcrOut == 0 && ierOut == 0 && mcrOut == 0 && irSelOut == 0, "R1 config regs",
          {lcrOut, ierOut, mcrOut, irSelOut}, 32'h0);
    check(divisorOut == 0 && !fifoMode && !rxReady, "R1 divisor/mode/ready",
          {divisorOut, 7'd0, fifoMode, 7'd0, rxReady}, 32'h0);
    check(busRData == 0, "R1 read data", busRData, 0);

    // R6 non-FIFO holding register, 8-bit chars
    wr(8'h0C, 32'h03, "R5");
    push(8'hA5, "R6");
    rd(8'h14, "R5 line status ready");
    rd(8'h00, "R6 read holding");
    rd(8'h00, "R6 read after empty");
    push(8'h3C, "R6");
    step(1, 0, 8'h00, 0, 1, 8'h96, "R6 push wins over read");
    rd(8'h00, "R6 second char");

    // R7 character length masking
    wr(8'h0C, 32'h00, "R7");
    push(8'hFF, "R7"); rd(8'h00, "R7 five bits");
    wr(8'h0C, 32'h01, "R7");
    push(8'hFF, "R7"); rd(8'h00, "R7 six bits");
    wr(8'h0C, 32'h02, "R7");
    push(8'hEE, "R7"); rd(8'h00, "R7 seven bits");

    // R2/R3 bank bit
    wr(8'h0C, 32'h83, "R2");
    wr(8'h00, 32'hFFFF_FF34, "R2 divisor low");
    wr(8'h04, 32'h12, "R3 divisor high");
    rd(8'h00, "R2 read divisor low");
    rd(8'h04, "R3 read divisor high");
    rd(8'h08, "R4 id with bank set");
    rd(8'h10, "R5 modem ctl with bank set");
    wr(8'h0C, 32'h03, "R2");
    wr(8'h00, 32'h5A, "R2 transmit");
    wr(8'h04, 32'h0F, "R3 int enable");
    rd(8'h04, "R3 read int enable");
    rd(8'h00, "R2 read rx empty");

    // R5 other registers and read-only offsets
    wr(8'h10, 32'h1B, "R5");
    wr(8'h1C, 32'hC3, "R5");
    wr(8'h20, 32'h07, "R5");
    wr(8'h14, 32'hFF, "R5 write lsr ignored");
    wr(8'h18, 32'hFF, "R5 write msr ignored");
    rd(8'h14, "R5 line status");
    rd(8'h18, "R5 modem status");
    rd(8'h1C, "R5 scratch");
    rd(8'h20, "R5 ir select");
    rd(8'h08, "R4 id read");

    // R9 unmapped offsets and low address bits
    wr(8'h24, 32'hAA, "R9 unmapped write");
    rd(8'h24, "R9 unmapped read");
    rd(8'hFC, "R9 top read");
    rd(8'h1F, "R9 low bits ignored");
    wr(8'h13, 32'h2D, "R9 low bits ignored write");
    rd(8'h10, "R9 modem ctl via aligned");

    // R8 FIFO mode
    wr(8'h08, 32'h01, "R4 enable fifo");
    push(8'h77, "R8 push ignored");
    rd(8'h00, "R8 empty fifo read");
    q.push_back(8'h11); q.push_back(8'h22); q.push_back(8'hC3);
    setFifoPins();
    @(negedge clk);
    check(rxReady == 1'b1, "R8 ready with data", 32'(rxReady), 32'h1);
    rd(8'h14, "R8 lsr ready");
    rd(8'h00, "R8 head 1");
    rd(8'h00, "R8 head 2");
    wr(8'h0C, 32'h02, "R7");
    rd(8'h00, "R8 head 3 seven bits");
    rd(8'h00, "R8 read empty no pop");
    wr(8'h08, 32'h00, "R4 disable fifo");
    rd(8'h00, "R4 holding cleared");
    step(0, 0, 0, 0, 0, 0, "R10 idle");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule